// File: doc/BRIEF.md
# Spread-Spectrum Triangular Offset Generator

This block runs on the reference clock of a clock synthesizer. It produces a signed word that tells the feedback divider how far the instantaneous frequency should sit from nominal. The word follows a triangle, which spreads the output energy over a band and lowers the spectral peaks that cause EMI. Software or pin straps supply four settings: a spread enable, a mode bit, a 4-bit magnitude code and the 9-bit reference divider value R. The period of the triangle comes from R, so each full triangle lasts 8·R reference cycles.

In center mode the profile starts at zero, climbs to +peak, descends through zero to −peak and climbs back to zero. In down mode it descends from zero to −peak and climbs back. Each ramp is produced by an exact remainder accumulator, so every corner of the triangle is hit with no drift. A new mode, code or R takes effect only at a period boundary, where the offset is zero. A one-cycle pulse marks the completion of every period.

Top module: `ssm_gen`

## Requirements
- R1: While `rst` is high (sampled on the clock), `offset` is 0 and `period_done` is 0 from the following edge.
- R2: On the edge after `spread_en` is sampled low, `offset` is exactly 0 and `period_done` is 0, even if a period was in progress.
- R3: In center mode (`mode_down`=0), with N=(code+1)·8, Re=max(R,1) and F(k)=floor(k·N/Re), the offset k edges into a period is F(k) for k≤2Re, 4N−F(k) for 2Re<k≤6Re and F(k)−8N above that. The peak is therefore ±(code+1)·16 LSB, where 1 LSB is 1/128 percent.
- R4: In down mode (`mode_down`=1), the offset k edges into a period is −F(k) for k≤4Re and F(k)−8N above that. The offset therefore reaches −(code+1)·32 LSB at k=4Re and is never positive.
- R5: Fractional slopes (N not a multiple of Re) follow the floor formula of R3/R4 on every cycle, with no accumulated error.
- R6: A period lasts 8·Re edges. `period_done` is high for exactly the one cycle in which the offset has returned to 0 at the period's end.
- R7: Mode, code and R are sampled at the edge that ends a period (or while disabled). Changes made during a period leave that period's profile unchanged, and the next period follows the new values.
- R8: An R value of 0 behaves exactly as R=1, giving an 8-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en | input | 1 | 1 runs the triangle, 0 forces the offset to zero |
| mode_down | input | 1 | 0 = center spread, 1 = down spread |
| mag_code | input | 4 | Spread magnitude code, 0..15 |
| ref_div | input | 9 | Reference divider R, which sets the period to 8·R cycles |
| offset | output | 11 | Signed frequency offset, 1 LSB = 1/128 percent |
| period_done | output | 1 | One-cycle pulse at the end of each period |

## Verification
The end of a period and the sampling of new settings fall on the same clock edge. The bench provokes this by changing the mode, code and R a few cycles into a running period and holding the new values through its end. The scoreboard expects the old profile through the cycle in which `period_done` pulses at offset zero, and the new profile from the very next cycle. A mid-period disable is also checked, so that dropping the enable is seen to win over the ramp on the following edge.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int DIV_W      = 9;
    localparam int CODE_W     = 4;
    localparam int OFF_W      = 11;
    localparam int UNIT_SHIFT = 3;
    localparam int SLOPE_W    = CODE_W + UNIT_SHIFT + 1;
    localparam int CNT_W      = DIV_W + 3;

    typedef enum logic {
        SPREAD_CENTER = 1'b0,
        SPREAD_DOWN   = 1'b1
    } spread_mode_e;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        spread_mode_e         mode;
        logic [DIV_W-1:0]     div;
        logic [SLOPE_W-1:0]   quo;
        logic [DIV_W-1:0]     rem;
        logic [OFF_W-1:0]     peak;
        logic [CNT_W-1:0]     t_q1;
        logic [CNT_W-1:0]     t_half;
        logic [CNT_W-1:0]     t_q3;
        logic [CNT_W-1:0]     t_last;
    } ssm_cfg_t;

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    // Per-cycle slope numerator, identical for both modes: (code+1)*8 LSB over R cycles
    function automatic logic [SLOPE_W-1:0] slope_num(input logic [CODE_W-1:0] c);
        logic [SLOPE_W-1:0] n;
        n = SLOPE_W'(c) + SLOPE_W'(1);
        return n << UNIT_SHIFT;
    endfunction

    function automatic ssm_cfg_t build_cfg(input logic              down,
                                           input logic [CODE_W-1:0] code,
                                           input logic [DIV_W-1:0]  rdiv);
        ssm_cfg_t          c;
        logic [DIV_W-1:0]  d;
        logic [DIV_W-1:0]  n9;
        logic [DIV_W-1:0]  q9;
        d        = eff_div(rdiv);
        n9       = DIV_W'(slope_num(code));
        q9       = n9 / d;
        c.mode   = down ? SPREAD_DOWN : SPREAD_CENTER;
        c.div    = d;
        c.quo    = SLOPE_W'(q9);
        c.rem    = n9 % d;
        c.peak   = down ? (OFF_W'(n9) << 2) : (OFF_W'(n9) << 1);
        c.t_q1   = CNT_W'(d) << 1;
        c.t_half = CNT_W'(d) << 2;
        c.t_q3   = (CNT_W'(d) << 1) + (CNT_W'(d) << 2);
        c.t_last = (CNT_W'(d) << 3) - CNT_W'(1);
        return c;
    endfunction

endpackage

// File: rtl/ssm_cfg_latch.sv
module ssm_cfg_latch
    import ssm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              mode_down,
    input  logic [CODE_W-1:0] mag_code,
    input  logic [DIV_W-1:0]  ref_div,
    output ssm_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg <= build_cfg(mode_down, mag_code, ref_div);
        end
    end

    // R8: a zero divider must give an 8-cycle period
    p_zero_div_r8: assert property (@(posedge clk) disable iff (rst)
        (load && ref_div == '0) |=> (cfg.t_last == CNT_W'(7) && cfg.div == DIV_W'(1)));

endmodule

// File: rtl/ssm_phase.sv
module ssm_phase
    import ssm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  spread_mode_e     mode,
    input  logic [CNT_W-1:0] t_q1,
    input  logic [CNT_W-1:0] t_half,
    input  logic [CNT_W-1:0] t_q3,
    input  logic [CNT_W-1:0] t_last,
    output ramp_dir_e        dir,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt;

    assign wrap = run && (cnt == t_last);

    always_ff @(posedge clk) begin
        if (rst || !run || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        if (mode == SPREAD_CENTER) begin
            if (cnt < t_q1) begin
                dir = DIR_RISE;
            end else if (cnt < t_q3) begin
                dir = DIR_FALL;
            end else begin
                dir = DIR_RISE;
            end
        end else begin
            dir = (cnt < t_half) ? DIR_FALL : DIR_RISE;
        end
    end

    // R6: the phase counter never runs past the last cycle of the period
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= t_last);

    // R6: an idle block restarts from the first cycle of a period
    p_idle_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/ssm_step_acc.sv
module ssm_step_acc
    import ssm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               clear,
    input  logic [DIV_W-1:0]   div,
    input  logic [SLOPE_W-1:0] quo,
    input  logic [DIV_W-1:0]   rem,
    output logic [SLOPE_W-1:0] step
);

    logic [DIV_W-1:0] acc;
    logic [DIV_W:0]   sum;
    logic             carry;

    assign sum   = {1'b0, acc} + {1'b0, rem};
    assign carry = (sum >= {1'b0, div});
    assign step  = quo + SLOPE_W'(carry);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (run) begin
            acc <= carry ? DIV_W'(sum - {1'b0, div}) : DIV_W'(sum);
        end
    end

    // R5: the remainder stays strictly below the divider
    p_rem_bound_r5: assert property (@(posedge clk) disable iff (rst)
        acc < div);

endmodule

// File: rtl/ssm_gen.sv
module ssm_gen
    import ssm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spread_en,
    input  logic                    mode_down,
    input  logic [CODE_W-1:0]       mag_code,
    input  logic [DIV_W-1:0]        ref_div,
    output logic signed [OFF_W-1:0] offset,
    output logic                    period_done
);

    ssm_cfg_t            cfg;
    ramp_dir_e           dir;
    logic                wrap;
    logic                load;
    logic [SLOPE_W-1:0]  step;
    logic signed [OFF_W-1:0] delta;

    assign load  = !spread_en || wrap;
    assign delta = signed'(OFF_W'(step));

    ssm_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .mode_down (mode_down),
        .mag_code  (mag_code),
        .ref_div   (ref_div),
        .cfg       (cfg)
    );

    ssm_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .run    (spread_en),
        .mode   (cfg.mode),
        .t_q1   (cfg.t_q1),
        .t_half (cfg.t_half),
        .t_q3   (cfg.t_q3),
        .t_last (cfg.t_last),
        .dir    (dir),
        .wrap   (wrap)
    );

    ssm_step_acc u_step (
        .clk   (clk),
        .rst   (rst),
        .run   (spread_en),
        .clear (load),
        .div   (cfg.div),
        .quo   (cfg.quo),
        .rem   (cfg.rem),
        .step  (step)
    );

    always_ff @(posedge clk) begin
        if (rst || !spread_en) begin
            offset      <= '0;
            period_done <= 1'b0;
        end else begin
            offset      <= (dir == DIR_RISE) ? (offset + delta) : (offset - delta);
            period_done <= wrap;
        end
    end

    // R1: reset clears the outputs on the following edge
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (offset == '0 && !period_done));

    // R2: disabling forces an exact zero on the next edge
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !spread_en |=> (offset == '0 && !period_done));

    // R3: center mode stays within +/- peak
    p_center_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == SPREAD_CENTER) |->
            (int'(offset) <= int'(cfg.peak) && int'(offset) >= -int'(cfg.peak)));

    // R4: down mode never goes positive and never passes -peak
    p_down_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == SPREAD_DOWN) |->
            (int'(offset) <= 0 && int'(offset) >= -int'(cfg.peak)));

    // R6: the end-of-period pulse lands on a zero offset
    p_done_zero_r6: assert property (@(posedge clk) disable iff (rst)
        period_done |-> (offset == '0));

    // R6: the pulse lasts a single cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        period_done |=> !period_done);

    // R7: the settings in use do not move inside a running period
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (spread_en && $past(spread_en) && !period_done) |-> $stable(cfg));

endmodule

// File: tb/test_ssm_gen.sv
module test_ssm_gen;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              spread_en = 1'b0;
    logic              mode_down = 1'b0;
    logic [3:0]        mag_code = 4'd0;
    logic [8:0]        ref_div = 9'd1;
    logic signed [10:0] offset;
    logic              period_done;

    typedef struct {
        int    off;
        bit    done;
        string tag;
    } item_t;

    item_t sb_q[$];
    item_t mon_it;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    ssm_gen i_ssm_gen (
        .clk         (clk),
        .rst         (rst),
        .spread_en   (spread_en),
        .mode_down   (mode_down),
        .mag_code    (mag_code),
        .ref_div     (ref_div),
        .offset      (offset),
        .period_done (period_done)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff(input int r);
        return (r == 0) ? 1 : r;
    endfunction

    // Expected offset k edges into a period (R3, R4, R5)
    function automatic int exp_off(input bit m, input int c, input int r, input int k);
        int re;
        int n;
        int f;
        re = eff(r);
        n  = (c + 1) * 8;
        f  = (k * n) / re;
        if (!m) begin
            if (k <= 2 * re) return f;
            else if (k <= 6 * re) return 4 * n - f;
            else return f - 8 * n;
        end else begin
            if (k <= 4 * re) return -f;
            else return f - 8 * n;
        end
    endfunction

    task automatic push_zero(input int n, input string tag);
        item_t it;
        for (int i = 0; i < n; i++) begin
            it.off = 0; it.done = 1'b0; it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic push_period(input bit m, input int c, input int r, input int cnt, input string tag);
        item_t it;
        int    len;
        len = 8 * eff(r);
        for (int k = 1; k <= cnt; k++) begin
            it.off  = exp_off(m, c, r, k);
            it.done = (k == len);
            it.tag  = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_fresh(input bit m, input int c, input int r, input int nper, input string tag);
        int len;
        len = 8 * eff(r);
        spread_en = 1'b0;
        mode_down = m;
        mag_code  = 4'(c);
        ref_div   = 9'(r);
        push_zero(2, "R2");
        wait_cycles(2);
        spread_en = 1'b1;
        for (int p = 0; p < nper; p++) push_period(m, c, r, len, tag);
        wait_cycles(nper * len);
    endtask

    // Monitor: compares one expected item per cycle, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                mon_it = sb_q.pop_front();
                check(mon_it.tag, "offset", int'(offset), mon_it.off);
                check(mon_it.tag, "period_done", int'(period_done), int'(mon_it.done));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1", "offset", int'(offset), 0);
        check("R1", "period_done", int'(period_done), 0);
        @(negedge clk);
        rst = 1'b0;

        run_fresh(1'b0, 3, 5, 2, "R3");
        run_fresh(1'b0, 15, 3, 1, "R3");
        run_fresh(1'b1, 5, 3, 1, "R4");
        run_fresh(1'b1, 15, 1, 1, "R4");
        run_fresh(1'b0, 1, 100, 1, "R5");
        run_fresh(1'b1, 2, 9, 1, "R5");
        run_fresh(1'b0, 6, 7, 1, "R6");
        run_fresh(1'b0, 15, 0, 2, "R8");
        run_fresh(1'b1, 15, 0, 1, "R8");

        // R7: new settings arrive mid-period and apply from the next period
        spread_en = 1'b0;
        mode_down = 1'b0; mag_code = 4'd15; ref_div = 9'd4;
        push_zero(2, "R2");
        wait_cycles(2);
        spread_en = 1'b1;
        push_period(1'b0, 15, 4, 32, "R7");
        push_period(1'b1, 0, 7, 56, "R7");
        wait_cycles(5);
        mode_down = 1'b1; mag_code = 4'd0; ref_div = 9'd7;
        wait_cycles(27 + 56);

        // R2: disable in the middle of a period
        spread_en = 1'b0;
        mode_down = 1'b0; mag_code = 4'd7; ref_div = 9'd6;
        push_zero(2, "R2");
        wait_cycles(2);
        spread_en = 1'b1;
        push_period(1'b0, 7, 6, 10, "R2");
        wait_cycles(10);
        spread_en = 1'b0;
        mag_code = 4'd12;
        push_zero(4, "R2");
        wait_cycles(4);

        @(posedge clk);
        #5;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule